// File: doc/BRIEF.md
# Stall-Then-Float Bus Takeover Arbiter

This block lets a second bus master borrow the address bus, data bus and read/write line of a running 6502-style processor without resetting it. The bus-enable pin of such a processor only switches its bus drivers to high impedance. It does not pause execution, so floating the bus while the processor still runs makes it fetch garbage. The arbiter therefore first stops the processor by pulling its ready input low and waits until the processor has actually halted. Only then does it float the processor's bus, and only after that does it hand the bus to the requester.

The processor's phase-2 clock comes in as a sampled input and passes through a configurable flop synchronizer before the arbiter uses it. A takeover waits until, with ready held low, the synchronized phase-2 has risen and then fallen, which shows that a full phase-2 high went by with the processor stalled. The hand-back runs in the reverse order. The requester's bus drivers turn off first, bus-enable rises one clock later, and ready rises one clock after that. The processor is then given one full synchronized phase-2 cycle of running before a new request is acted on.

Top module: `bus_takeover_arb`

## Requirements
- R1: After synchronous reset, cpu_rdy=1, cpu_be=1, gnt=0 and ext_drv_en=0.
- R2: A request (req=1) seen at a clock edge while the arbiter is idle drives cpu_rdy low from that edge onward.
- R3: cpu_be is low only in cycles where cpu_rdy is also low.
- R4: gnt rises only after the synchronized phase-2 (phi2_in delayed through SYNC_STAGES flops) has risen and then fallen while cpu_rdy was low.
- R5: gnt rises exactly one clock after cpu_be falls.
- R6: While req stays high, gnt stays high, and ext_drv_en always equals gnt.
- R7: One clock after req is seen low during a grant, gnt and ext_drv_en are both low.
- R8: cpu_be rises exactly one clock after ext_drv_en falls.
- R9: cpu_rdy rises exactly one clock after cpu_be rises.
- R10: Once cpu_rdy has risen, it does not fall again until the synchronized phase-2 has risen and then fallen. A request that arrives during the hand-back or this wait is held until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than phase-2 |
| rst | input | 1 | Synchronous active-high reset |
| phi2_in | input | 1 | Sampled phase-2 clock of the processor |
| req | input | 1 | Bus request from the external master, held for the whole use |
| gnt | output | 1 | Bus granted to the external master |
| ext_drv_en | output | 1 | Enable for the external master's bus drivers |
| cpu_rdy | output | 1 | Ready to the processor, low stalls it |
| cpu_be | output | 1 | Bus enable to the processor, low floats its bus |

## Verification
The bench builds the block with SYNC_STAGES=2 and sweeps the phase-2 half period from 2 to 6 system clocks, with every request start offset inside one phase-2 period. This puts a request just before, on and just after each phase-2 edge, so the stall window meets both its shortest and its longest wait. Each point runs twice: once with a clean release, and once with a new request raised during the hand-back. The second run reaches the resume hold of R10. The bench keeps its own delay line of phase-2 samples to decide when a full synchronized high or cycle has passed.

// File: rtl/bto_pkg.sv
package bto_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_STALL   = 3'd1,
        ST_FLOAT   = 3'd2,
        ST_GRANT   = 3'd3,
        ST_DRVOFF  = 3'd4,
        ST_UNFLOAT = 3'd5,
        ST_RESUME  = 3'd6
    } arb_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } phase_evt_t;

    typedef struct packed {
        logic rdy;
        logic be;
        logic gnt;
        logic drv;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_RUN = '{rdy: 1'b1, be: 1'b1, gnt: 1'b0, drv: 1'b0};

    function automatic bus_ctl_t ctl_for(arb_state_e s);
        bus_ctl_t c;
        c = CTL_RUN;
        case (s)
            ST_STALL:   c = '{rdy: 1'b0, be: 1'b1, gnt: 1'b0, drv: 1'b0};
            ST_FLOAT:   c = '{rdy: 1'b0, be: 1'b0, gnt: 1'b0, drv: 1'b0};
            ST_GRANT:   c = '{rdy: 1'b0, be: 1'b0, gnt: 1'b1, drv: 1'b1};
            ST_DRVOFF:  c = '{rdy: 1'b0, be: 1'b0, gnt: 1'b0, drv: 1'b0};
            ST_UNFLOAT: c = '{rdy: 1'b0, be: 1'b1, gnt: 1'b0, drv: 1'b0};
            default:    c = CTL_RUN;
        endcase
        return c;
    endfunction

    function automatic logic counts_phase(arb_state_e s);
        return (s == ST_STALL) || (s == ST_RESUME);
    endfunction

endpackage

// File: rtl/bto_phase_sync.sv
module bto_phase_sync
    import bto_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       phi2_in,
    output phase_evt_t evt
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              last_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= phi2_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[LAST];
    end

    always_comb begin
        evt.rise = chain[LAST] & ~last_q;
        evt.fall = ~chain[LAST] & last_q;
    end
endmodule

// File: rtl/bto_seq_fsm.sv
module bto_seq_fsm
    import bto_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  phase_evt_t evt,
    output arb_state_e state_q,
    output bus_ctl_t   ctl
);
    arb_state_e state_d;
    logic       rose_q;
    logic       rose_d;

    always_comb begin
        rose_d = counts_phase(state_q) ? (rose_q | evt.rise) : 1'b0;
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (req) state_d = ST_STALL;
            ST_STALL:   if (evt.fall && rose_q) state_d = ST_FLOAT;
            ST_FLOAT:   state_d = ST_GRANT;
            ST_GRANT:   if (!req) state_d = ST_DRVOFF;
            ST_DRVOFF:  state_d = ST_UNFLOAT;
            ST_UNFLOAT: state_d = ST_RESUME;
            ST_RESUME:  if (evt.fall && rose_q) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        if (state_d != state_q) rose_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rose_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            rose_q  <= rose_d;
        end
    end

    assign ctl = ctl_for(state_q);
endmodule

// File: rtl/bus_takeover_arb.sv
module bus_takeover_arb
    import bto_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic phi2_in,
    input  logic req,
    output logic gnt,
    output logic ext_drv_en,
    output logic cpu_rdy,
    output logic cpu_be
);
    phase_evt_t evt;
    arb_state_e cur_state;
    bus_ctl_t   ctl;

    bto_phase_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .phi2_in (phi2_in),
        .evt     (evt)
    );

    bto_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .evt     (evt),
        .state_q (cur_state),
        .ctl     (ctl)
    );

    assign cpu_rdy    = ctl.rdy;
    assign cpu_be     = ctl.be;
    assign gnt        = ctl.gnt;
    assign ext_drv_en = ctl.drv;
endmodule

// File: rtl/bto_arb_chk.sv
module bto_arb_chk
    import bto_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req,
    input logic       gnt,
    input logic       drv,
    input logic       rdy,
    input logic       be,
    input arb_state_e st
);
    // R2
    stall_on_req_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && req) |=> !rdy);

    // R3
    float_needs_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !be |-> !rdy);

    // R5
    grant_after_float_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gnt) |-> ($past(!be) && $past(!gnt)));

    // R6
    grant_held_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt && req) |=> gnt);

    // R7
    grant_release_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt && !req) |=> (!gnt && !drv));

    // R8
    drivers_off_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(be) |-> $past(!drv));

    // R9
    ready_after_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> ($past(be) && $past(!rdy)));
endmodule

bind bus_takeover_arb bto_arb_chk u_chk (
    .clk (clk),
    .rst (rst),
    .req (req),
    .gnt (gnt),
    .drv (ext_drv_en),
    .rdy (cpu_rdy),
    .be  (cpu_be),
    .st  (cur_state)
);

// File: tb/bus_takeover_arb_test.sv
`timescale 1ns/100ps
module bus_takeover_arb_test;
    localparam int N = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phi2 = 1'b0;
    logic req = 1'b0;
    logic gnt, drv, rdy, be;

    int checks = 0;
    int failures = 0;
    int half = 3;

    always #2.5 clk = ~clk;

    bus_takeover_arb #(.SYNC_STAGES(N)) uut (
        .clk (clk), .rst (rst), .phi2_in (phi2), .req (req),
        .gnt (gnt), .ext_drv_en (drv), .cpu_rdy (rdy), .cpu_be (be)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    // phase-2 generator, steps just after a rising clock edge
    initial begin
        wait (!rst);
        forever begin
            repeat (half) @(posedge clk);
            #1 phi2 = ~phi2;
        end
    end

    // monitor state
    logic hist [0:N];
    logic pdv = 1'b0;
    logic sr = 1'b0, full = 1'b0;
    logic armed = 1'b0, rsr = 1'b0, rfull = 1'b0;
    logic p_rdy = 1'b1, p_be = 1'b1, pp_be = 1'b1, p_gnt = 1'b0;
    logic p_drv = 1'b0, pp_drv = 1'b0, p_req = 1'b0;

    initial for (int i = 0; i <= N; i++) hist[i] = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            logic dv;
            for (int i = N; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = phi2;
            dv = hist[N];
            if (!rdy) begin
                if (!dv && pdv && sr) full = 1'b1;
                if (dv && !pdv) sr = 1'b1;
            end else begin
                sr = 1'b0; full = 1'b0;
            end
            if (rdy && !p_rdy) begin
                armed = 1'b1; rsr = 1'b0; rfull = 1'b0;
            end
            if (rdy && armed) begin
                if (!dv && pdv && rsr) rfull = 1'b1;
                if (dv && !pdv) rsr = 1'b1;
            end
            // R3 and R6 every cycle
            if (!be) chk("R3 be low while rdy", rdy, 1'b0);
            chk("R6 drv follows gnt", drv, gnt);
            if (gnt && !p_gnt) begin
                chk("R4 full phase before grant", full, 1'b1);
                chk("R5 be fell one clock before gnt", p_be == 1'b0 && pp_be == 1'b1, 1'b1);
            end
            if (p_gnt && p_req) chk("R6 gnt held", gnt, 1'b1);
            if (p_gnt && !p_req) chk("R7 gnt/drv drop", gnt | drv, 1'b0);
            if (be && !p_be) chk("R8 drv off one clock before be", p_drv == 1'b0 && pp_drv == 1'b1, 1'b1);
            if (rdy && !p_rdy) chk("R9 be rose one clock before rdy", p_be == 1'b1 && pp_be == 1'b0, 1'b1);
            if (!rdy && p_rdy && armed) begin
                chk("R10 phase cycle before restall", rfull, 1'b1);
                armed = 1'b0;
            end
            pdv = dv;
            pp_be = p_be; p_be = be; p_rdy = rdy; p_gnt = gnt;
            pp_drv = p_drv; p_drv = drv; p_req = req;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic wait_grant(input string tag);
        int n;
        n = 0;
        while (gnt !== 1'b1 && n < 200) begin
            @(negedge clk); n++;
        end
        chk(tag, gnt, 1'b1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 reset rdy", rdy, 1'b1);
        chk("R1 reset be", be, 1'b1);
        chk("R1 reset gnt", gnt, 1'b0);
        chk("R1 reset drv", drv, 1'b0);
        @(posedge clk); #1 rst = 1'b0;

        for (int hp = 2; hp <= 6; hp++) begin
            half = hp;
            for (int off = 0; off < 2 * hp; off++) begin
                for (int v = 0; v < 2; v++) begin
                    repeat (2 * hp + 2 * N + 8) @(posedge clk);
                    repeat (off) @(posedge clk);
                    #1 req = 1'b1;
                    @(negedge clk);
                    chk("R2 rdy before sampling", rdy, 1'b1);
                    @(negedge clk);
                    chk("R2 rdy low after request", rdy, 1'b0);
                    wait_grant("R4 grant reached");
                    repeat (off % 3) @(posedge clk);
                    @(posedge clk); #1 req = 1'b0;
                    if (v == 1) begin
                        // R10: request raised during hand-back
                        @(posedge clk); #1 req = 1'b1;
                        @(negedge clk);
                        chk("R7 gnt low during hand-back", gnt, 1'b0);
                        wait_grant("R10 held request granted");
                        @(posedge clk); #1 req = 1'b0;
                    end
                end
            end
        end
        repeat (40) @(posedge clk);
        summary();
    end
endmodule